// File: doc/BRIEF.md
# Multi-Rail Supervisor Reset Sequencer

This block is the digital half of a processor supervisor. Analog comparators outside it report, for each of up to three supply rails, whether that rail is above its threshold. A pushbutton, pulled to ground when pressed, arrives as an active-low request. From these inputs the block produces one active-low system reset. The reset is released only after every enabled rail has been good for a qualifying run and then a timeout has passed with nothing wrong. The reset is applied again when a rail stays low past a glitch window, or when a press is long enough to count.

Every input is asynchronous, so each one goes through a two-flop synchronizer. A single run-length filter then qualifies each rail and the pushbutton. The filter has one threshold for the rising direction and another for the falling direction, so the same filter rejects short supply dips and debounces contact ringing. A timer takes the combined fault and holds reset until a full timeout of clean cycles has been counted. This applies to every cause, the block's own power-on initialisation included. All durations are parameters counted in clock cycles.

Top module: `rail_reset_supervisor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sys_rst_n` is 0.
- R2: A rail counts as good only after its synchronized flag has been 1 on RAIL_QUAL_CYC consecutive cycles. Any 0 sample before that point restarts the count.
- R3: `sys_rst_n` goes to 1 only after every enabled rail is qualified good, no press is held, and TIMEOUT_CYC further consecutive clean cycles have passed. With all rails steady from reset, it rises exactly 2 + RAIL_QUAL_CYC + TIMEOUT_CYC clock edges after `rst_n` goes high.
- R4: A rail dip lasting fewer than GLITCH_CYC cycles has no effect on `sys_rst_n`.
- R5: A dip on an enabled rail lasting GLITCH_CYC cycles drives `sys_rst_n` to 0 exactly 3 + GLITCH_CYC edges after the raw flag falls.
- R6: A rail whose `rail_en` bit is 0 has no effect on `sys_rst_n`, whatever its flag does.
- R7: A low pulse on `mr_n_raw` shorter than MR_VALID_CYC cycles has no effect on `sys_rst_n`.
- R8: A low pulse on `mr_n_raw` of at least MR_VALID_CYC cycles drives `sys_rst_n` to 0. A press counts as released only after MR_RELEASE_CYC consecutive high cycles, so ringing yields one reset event.
- R9: Once the last cause clears, `sys_rst_n` stays 0 for TIMEOUT_CYC more cycles. A clean press of MR_VALID_CYC cycles keeps it low for MR_RELEASE_CYC + TIMEOUT_CYC - 1 cycles. A new cause during the timeout restarts the count.
- R10: Raw inputs reach the filters only through two synchronizer flops. The reset values are rails bad and button released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| rail_en | input | NUM_RAILS | 1 = rail is monitored |
| rail_good_raw | input | NUM_RAILS | Asynchronous comparator flag per rail, 1 = above threshold |
| mr_n_raw | input | 1 | Asynchronous pushbutton, 0 = pressed |
| sys_rst_n | output | 1 | System reset, 0 = held in reset |

## Verification
The bound assertions check the cycle-level rules on every cycle. Reset is held during initialisation. A rail or press changes its qualified state only after a matching synchronized sample. Any fault drops the output on the next edge, and a disabled rail cannot hold reset. A side counter confirms that every release follows a full timeout. The exact latencies, the rejection of short dips and short presses, the single event produced by a ringing button, and the restart of the timeout depend on sequences of inputs. Only the bench's directed and random scenarios can show these, checked against its cycle model.

// File: rtl/rrs_pkg.sv
// Shared types for the multi-rail reset sequencer.
package rrs_pkg;
    // Timer states: holding the system in reset, or running.
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } rrs_state_e;
endpackage

// File: rtl/rrs_sync2.sv
// Two-flop synchronizer, W bits wide.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module rrs_sync2 #(
    parameter int unsigned     W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two flop stages in series, loaded with RST_VAL during initialisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/rrs_run_filter.sv
// Asymmetric run-length filter. The output follows the input only after the
// input has disagreed with it for RISE_CYC (0->1) or FALL_CYC (1->0)
// consecutive cycles. Any agreeing sample clears the run.
// Assumes the input is already synchronous. The output resets to 0.
module rrs_run_filter #(
    parameter int unsigned RISE_CYC = 8,
    parameter int unsigned FALL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);
    localparam int unsigned MAXC = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);

    logic [CW-1:0] run_q;
    logic          run_done;

    // Current run has reached the threshold for the pending direction.
    always_comb begin
        run_done = level_out ? (run_q == FALL_LAST) : (run_q == RISE_LAST);
    end

    // Count disagreeing samples and flip the output at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_out <= 1'b0;
            run_q     <= '0;
        end else if (level_in != level_out) begin
            if (run_done) begin
                level_out <= level_in;
                run_q     <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end
endmodule

// File: rtl/rrs_reset_timer.sv
// Reset timeout timer. Holds the system in reset while fault is high.
// Releases it after TIMEOUT_CYC consecutive fault-free cycles.
// Assumes fault is synchronous. Starts in the hold state.
module rrs_reset_timer
    import rrs_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic sys_rst_n
);
    localparam int unsigned   CW   = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    rrs_state_e    state_q;
    logic [CW-1:0] cnt_q;

    // Fault forces hold and clears the count; a full clean count releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else if (fault) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else if (state_q == ST_HOLD) begin
            if (cnt_q == LAST) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sys_rst_n = (state_q == ST_RUN);
endmodule

// File: rtl/rail_reset_supervisor.sv
// Multi-rail supervisor reset sequencer (top).
// Synchronizes the rail flags and the pushbutton, then qualifies each one
// with a run-length filter. The combined fault drives the timeout timer.
// Assumes the comparator flags are 1 when a rail is good and the pushbutton is
// 0 when pressed. Durations are in clk cycles.
module rail_reset_supervisor #(
    parameter int unsigned NUM_RAILS      = 3,
    parameter int unsigned RAIL_QUAL_CYC  = 8,
    parameter int unsigned GLITCH_CYC     = 4,
    parameter int unsigned MR_VALID_CYC   = 6,
    parameter int unsigned MR_RELEASE_CYC = 5,
    parameter int unsigned TIMEOUT_CYC    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic [NUM_RAILS-1:0] rail_good_raw,
    input  logic                 mr_n_raw,
    output logic                 sys_rst_n
);
    logic [NUM_RAILS-1:0] rail_sync;
    logic [NUM_RAILS-1:0] rail_ok;
    logic                 mr_sync;
    logic                 mr_hold;
    logic                 fault;

    rrs_sync2 #(.W(NUM_RAILS), .RST_VAL('0)) u_rail_sync (
        .clk(clk), .rst_n(rst_n), .d_async(rail_good_raw), .q_sync(rail_sync)
    );

    rrs_sync2 #(.W(1), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst_n(rst_n), .d_async(mr_n_raw), .q_sync(mr_sync)
    );

    // One filter per rail: slow to trust a rail, quick to drop it.
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        rrs_run_filter #(.RISE_CYC(RAIL_QUAL_CYC), .FALL_CYC(GLITCH_CYC)) u_filt (
            .clk(clk), .rst_n(rst_n), .level_in(rail_sync[i]), .level_out(rail_ok[i])
        );
    end

    // Pushbutton filter: minimum press width, then debounced release.
    rrs_run_filter #(.RISE_CYC(MR_VALID_CYC), .FALL_CYC(MR_RELEASE_CYC)) u_mr_filt (
        .clk(clk), .rst_n(rst_n), .level_in(~mr_sync), .level_out(mr_hold)
    );

    // Any enabled rail not qualified, or a held press, is a fault.
    always_comb begin
        fault = (|(rail_en & ~rail_ok)) | mr_hold;
    end

    rrs_reset_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .fault(fault), .sys_rst_n(sys_rst_n)
    );
endmodule

// File: rtl/rrs_checker.sv
// Assertion checker for rail_reset_supervisor, attached by bind.
// Relates the filter outputs to their synchronized inputs, and the output to
// the fault. A side counter bounds each release by the timeout.
module rrs_checker #(
    parameter int unsigned NUM_RAILS   = 3,
    parameter int unsigned TIMEOUT_CYC = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic [NUM_RAILS-1:0] rail_sync,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 mr_sync,
    input logic                 mr_hold,
    input logic                 fault,
    input logic                 sys_rst_n
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 2);
    logic [CW-1:0] clean_cnt;

    // Consecutive fault-free cycles, saturating just above the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || fault)
            clean_cnt <= '0;
        else if (clean_cnt <= CW'(TIMEOUT_CYC))
            clean_cnt <= clean_cnt + 1'b1;
    end

    // R1
    init_hold_chk: assert property (@(posedge clk) !rst_n |=> !sys_rst_n);

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail_chk
        // R2
        rail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_ok[i]) |-> $past(rail_sync[i]));
        // R5
        rail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rail_ok[i]) |-> !$past(rail_sync[i]));
    end

    // R5
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && fault) |=> !sys_rst_n);

    // R6
    enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && !mr_hold && ((rail_ok | ~rail_en) == '1)) |=> sys_rst_n);

    // R8
    press_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_hold) |-> !$past(mr_sync));

    // R9
    full_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (clean_cnt >= CW'(TIMEOUT_CYC)));
endmodule

bind rail_reset_supervisor rrs_checker #(
    .NUM_RAILS(NUM_RAILS), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_rrs_checker (
    .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .rail_sync(rail_sync),
    .rail_ok(rail_ok), .mr_sync(mr_sync), .mr_hold(mr_hold),
    .fault(fault), .sys_rst_n(sys_rst_n)
);

// File: tb/rail_reset_supervisor_bench.sv
// Bench: directed corner cases plus seeded random stimulus. A cycle model
// built from the requirements is compared with the output on every cycle.
module rail_reset_supervisor_bench;
    localparam int NR   = 3;
    localparam int QUAL = 8;
    localparam int GLT  = 4;
    localparam int MRV  = 6;
    localparam int MRR  = 5;
    localparam int TMO  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_en = '1;
    logic [NR-1:0] rail_good_raw = '1;
    logic          mr_n_raw = 1'b1;
    logic          sys_rst_n;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    rail_reset_supervisor #(
        .NUM_RAILS(NR), .RAIL_QUAL_CYC(QUAL), .GLITCH_CYC(GLT),
        .MR_VALID_CYC(MRV), .MR_RELEASE_CYC(MRR), .TIMEOUT_CYC(TMO)
    ) u_rail_reset_supervisor (
        .clk(clk), .rst_n(rst_n), .rail_en(rail_en),
        .rail_good_raw(rail_good_raw), .mr_n_raw(mr_n_raw), .sys_rst_n(sys_rst_n)
    );

    // Cycle model: two-sample input delay (R10), run counts (R2 R4 R5 R7 R8), timeout (R3 R9).
    logic [NR-1:0] m_s1, m_s2, m_ok;
    logic          m_b1, m_b2, m_hold, m_out;
    int            m_gr [NR];
    int            m_br [NR];
    int            m_lo, m_hi, m_clean;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_ok <= '0;
            m_b1 <= 1'b1; m_b2 <= 1'b1; m_hold <= 1'b0; m_out <= 1'b0;
            m_lo <= 0; m_hi <= 0; m_clean <= 0;
            for (int i = 0; i < NR; i++) begin m_gr[i] <= 0; m_br[i] <= 0; end
        end else begin
            bit cause;
            int ng, nb, nlo, nhi;
            cause = ((rail_en & ~m_ok) != '0) || m_hold;
            m_s1 <= rail_good_raw; m_s2 <= m_s1;
            m_b1 <= mr_n_raw;      m_b2 <= m_b1;
            for (int i = 0; i < NR; i++) begin
                ng = m_s2[i] ? (m_gr[i] < 1000 ? m_gr[i] + 1 : 1000) : 0;
                nb = m_s2[i] ? 0 : (m_br[i] < 1000 ? m_br[i] + 1 : 1000);
                m_gr[i] <= ng; m_br[i] <= nb;
                if (!m_ok[i] && ng >= QUAL) m_ok[i] <= 1'b1;
                else if (m_ok[i] && nb >= GLT) m_ok[i] <= 1'b0;
            end
            nlo = m_b2 ? 0 : (m_lo < 1000 ? m_lo + 1 : 1000);
            nhi = m_b2 ? (m_hi < 1000 ? m_hi + 1 : 1000) : 0;
            m_lo <= nlo; m_hi <= nhi;
            if (!m_hold && nlo >= MRV) m_hold <= 1'b1;
            else if (m_hold && nhi >= MRR) m_hold <= 1'b0;
            m_clean <= cause ? 0 : (m_clean < 1000 ? m_clean + 1 : 1000);
            m_out   <= cause ? 1'b0 : (m_out || (m_clean + 1 >= TMO));
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sys_rst_n actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous comparison with the model, tagged with the current scenario.
    always @(negedge clk) check(cur_req, sys_rst_n, m_out);

    // Falling-edge counter for the single-event check.
    int   falls = 0;
    logic prev_out = 1'b0;
    always @(negedge clk) begin
        if (prev_out && !sys_rst_n) falls++;
        prev_out = sys_rst_n;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        int lowlen;
        int dip_left [NR];
        int mr_left;
        void'($urandom(32'd20240611));

        // R1: reset held, and first cycle after release
        step(5);
        check("R1", sys_rst_n, 1'b0);
        rst_n = 1'b1;
        step(1);
        check("R1", sys_rst_n, 1'b0);

        // R3: release exactly 2+QUAL+TMO edges after reset release (R10 latency included)
        cur_req = "R3";
        step(2 + QUAL + TMO - 2);
        check("R3", sys_rst_n, 1'b0);
        step(1);
        check("R3", sys_rst_n, 1'b1);
        step(5);

        // R4: dip of GLT-1 cycles ignored
        cur_req = "R4";
        rail_good_raw[0] = 1'b0; step(GLT - 1); rail_good_raw[0] = 1'b1;
        step(15);
        check("R4", sys_rst_n, 1'b1);

        // R5: dip of GLT cycles asserts reset 3+GLT edges after the fall
        cur_req = "R5";
        rail_good_raw[1] = 1'b0;
        step(3 + GLT - 1);
        check("R5", sys_rst_n, 1'b1);
        step(1);
        check("R5", sys_rst_n, 1'b0);
        rail_good_raw[1] = 1'b1;
        step(2 + QUAL + TMO + 5);
        check("R5", sys_rst_n, 1'b1);

        // R6: disabled rail held bad has no effect
        cur_req = "R6";
        rail_en[2] = 1'b0; rail_good_raw[2] = 1'b0;
        step(60);
        check("R6", sys_rst_n, 1'b1);
        rail_good_raw[2] = 1'b1; step(QUAL + 4); rail_en[2] = 1'b1;
        step(5);
        check("R6", sys_rst_n, 1'b1);

        // R7: press shorter than MRV ignored
        cur_req = "R7";
        mr_n_raw = 1'b0; step(MRV - 1); mr_n_raw = 1'b1;
        step(MRR + 15);
        check("R7", sys_rst_n, 1'b1);

        // R9: clean press gives low time of MRR+TMO-1 cycles
        cur_req = "R9";
        mr_n_raw = 1'b0; step(MRV); mr_n_raw = 1'b1;
        while (sys_rst_n) step(1);
        lowlen = 0;
        while (!sys_rst_n && lowlen < 500) begin step(1); lowlen++; end
        checks++;
        if (lowlen != MRR + TMO - 1) begin
            errors++;
            $display("FAIL R9: low length actual=%0d expected=%0d", lowlen, MRR + TMO - 1);
        end
        step(5);

        // R8: ringing press gives exactly one reset event
        cur_req = "R8";
        falls = 0;
        mr_n_raw = 1'b0; step(MRV + 2);
        for (int k = 0; k < 4; k++) begin
            mr_n_raw = 1'b1; step(MRR - 2);
            mr_n_raw = 1'b0; step(1);
        end
        mr_n_raw = 1'b1;
        step(MRR + TMO + 10);
        checks++;
        if (falls != 1) begin
            errors++;
            $display("FAIL R8: reset events actual=%0d expected=1", falls);
        end
        check("R8", sys_rst_n, 1'b1);

        // R9: rail fault during the timeout restarts it
        cur_req = "R9";
        rail_good_raw[0] = 1'b0; step(GLT + 1); rail_good_raw[0] = 1'b1;
        step(QUAL + 2 + TMO / 2);
        rail_good_raw[2] = 1'b0; step(GLT + 1); rail_good_raw[2] = 1'b1;
        step(QUAL + 4 + TMO - 4);
        check("R9", sys_rst_n, 1'b0);
        step(10);
        check("R9", sys_rst_n, 1'b1);

        // R2: a bad sample during qualification restarts it
        cur_req = "R2";
        rail_good_raw[1] = 1'b0; step(GLT + 2);
        rail_good_raw[1] = 1'b1; step(QUAL - 2);
        rail_good_raw[1] = 1'b0; step(1);
        rail_good_raw[1] = 1'b1;
        step(2 + QUAL + TMO - 2);
        check("R2", sys_rst_n, 1'b0);
        step(2);
        check("R2", sys_rst_n, 1'b1);

        // Random mix; model comparison covers R2 to R10 jointly
        cur_req = "R3";
        for (int i = 0; i < NR; i++) dip_left[i] = 0;
        mr_left = 0;
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(0, 39) == 0) dip_left[$urandom_range(0, NR - 1)] = $urandom_range(1, 9);
            if (mr_left == 0 && $urandom_range(0, 149) == 0) mr_left = $urandom_range(1, 12);
            if ($urandom_range(0, 499) == 0) rail_en[$urandom_range(0, NR - 1)] ^= 1'b1;
            for (int i = 0; i < NR; i++) begin
                rail_good_raw[i] = (dip_left[i] == 0);
                if (dip_left[i] > 0) dip_left[i]--;
            end
            mr_n_raw = (mr_left == 0);
            if (mr_left > 0) mr_left--;
            step(1);
        end
        rail_good_raw = '1; mr_n_raw = 1'b1;
        step(100);
        finish_run();
    end
endmodule